// File: doc/BRIEF.md
# I2C SCL Clock Divider

This block turns a single peripheral clock into I2C bit timing in two stages. A prescaler divides the input clock by one plus a small divide field (`cdf`) and emits a one-cycle tick strobe. The tick strobe lets all downstream logic stay on the input clock. The tick rate is meant to stay below 20 MHz.

A phase controller builds each SCL period from those ticks. The base count of 20 + 8·`scgd` ticks is split evenly between a driven-low phase and a released-high phase. Between the two phases there is a rise-wait stage. In that stage SCL has been released, but the high-phase count does not start until the synchronized bus level actually reads high. The rise-wait therefore absorbs the bus rise time, the internal delay and any clock stretching by another device.

Configuration arrives as one packed word with `scgd` placed directly above `cdf`. The width of `cdf` is a parameter of 2 or 3 bits. A new word is adopted only while the block is idle or at the boundary between two periods. The byte engine receives one shift strobe in the middle of each low phase and one sample strobe in the middle of each high phase.

Top module: `scl_clk_div`

## Requirements
- R1: While running, a tick pulse occurs once every `cdf`+1 input clock cycles. The first tick of a phase comes `cdf` cycles after the phase starts. The low phase contains exactly H = 10 + 4·`scgd` ticks, and so does the high phase.
- R2: SCL is driven low (`scl_oe_o`=1) for exactly H·(`cdf`+1) consecutive cycles per period.
- R3: After release, the high-phase count starts only when the synchronized `scl_i` reads high. With two synchronizer stages and no stretching, the released time is H·(`cdf`+1)+3 cycles.
- R4: If an external device holds SCL low for S cycles after release, the released time grows by exactly S cycles. The high phase itself stays H ticks long.
- R5: The configuration word is decoded as `cdf` = `cfg_i[CDF_W-1:0]` and `scgd` = `cfg_i[CDF_W+5:CDF_W]` (6 bits, 0 to 63), for both CDF_W = 3 and CDF_W = 2.
- R6: A change on `cfg_i` during a period does not alter that period. The new value is used from the next period on, and the value present while idle is used for the first period.
- R7: While `en_i` is low, or from the cycle after it is sampled low, SCL is released, and tick, shift and sample all stay low. A re-enable then starts a full fresh period.
- R8: Each period carries exactly one `shift_o` pulse, which falls inside the low phase, and exactly one `sample_o` pulse, which falls inside the released phase. Both coincide with a tick.
- R9: A low phase begins in the cycle after `en_i` is first sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low releases SCL and holds all counters |
| cfg_i | input | CDF_W+SCGD_W | Packed divider word, `scgd` above `cdf` |
| scl_i | input | 1 | Observed SCL bus level (asynchronous) |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| tick_o | output | 1 | Internal tick strobe |
| shift_o | output | 1 | Mid-low strobe for driving the next data bit |
| sample_o | output | 1 | Mid-high strobe for sampling SDA |

## Verification
The bench builds two copies of the block. One uses the default 3-bit divide field and the other a 2-bit field, both with two synchronizer stages. Running both shows that the same `scgd` value is found at different bit positions of the configuration word. The 3-bit copy reaches the largest setting (divide by 8, `scgd` 63, 2096-cycle low phase) as well as a divide by 1. That covers both ends of the prescaler and period counter ranges. The two-stage synchronizer makes the rise-wait a fixed three cycles, so stretch lengths can be predicted exactly.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_RISE = 2'd2,
    PH_HIGH = 2'd3
  } scl_phase_e;

  // half period = (20 + 8*scgd) / 2
  localparam int unsigned HALF_BASE  = 10;
  localparam int unsigned HALF_SHIFT = 2;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int unsigned CDF_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CDF_W-1:0] cdf_i,
  output logic             tick_o
);
  logic [CDF_W-1:0] pcnt_q;
  logic             wrap;

  assign wrap   = (pcnt_q == cdf_i);
  assign tick_o = run_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pcnt_q <= '0;
    else if (!run_i)  pcnt_q <= '0;
    else if (wrap)    pcnt_q <= '0;
    else              pcnt_q <= pcnt_q + 1'b1;
  end
endmodule

// File: rtl/scl_sync.sv
module scl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else         chain_q[g] <= (g == 0) ? d_i : chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch
  import scl_div_pkg::*;
#(
  parameter int unsigned CDF_W  = 3,
  parameter int unsigned SCGD_W = 6,
  parameter int unsigned CNT_W  = SCGD_W + 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic [CDF_W+SCGD_W-1:0] cfg_i,
  output logic [CDF_W-1:0]        cdf_o,
  output logic [CNT_W-1:0]        half_o
);
  logic [SCGD_W-1:0] scgd;
  logic [CNT_W-1:0]  half_n;

  assign scgd   = cfg_i[CDF_W +: SCGD_W];
  assign half_n = CNT_W'(HALF_BASE) + (CNT_W'(scgd) << HALF_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cdf_o  <= '0;
      half_o <= CNT_W'(HALF_BASE);
    end else if (load_i) begin
      cdf_o  <= cfg_i[CDF_W-1:0];
      half_o <= half_n;
    end
  end
endmodule

// File: rtl/scl_phase_ctrl.sv
module scl_phase_ctrl
  import scl_div_pkg::*;
#(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic             scl_hi_i,
  input  logic [CNT_W-1:0] half_i,
  output logic             run_o,
  output logic             load_o,
  output logic             scl_oe_o,
  output logic             shift_o,
  output logic             sample_o
);
  scl_phase_e       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic             last_tick;
  logic             mid_tick;

  assign last_tick = tick_i && (cnt_q == half_i - 1'b1);
  assign mid_tick  = tick_i && (cnt_q == (half_i >> 1));

  assign run_o    = en_i && ((phase_q == PH_LOW) || (phase_q == PH_HIGH));
  assign load_o   = (phase_q == PH_IDLE) || ((phase_q == PH_HIGH) && last_tick);
  assign scl_oe_o = (phase_q == PH_LOW);
  assign shift_o  = (phase_q == PH_LOW)  && mid_tick;
  assign sample_o = (phase_q == PH_HIGH) && mid_tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else if (!en_i) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          phase_q <= PH_LOW;
          cnt_q   <= '0;
        end
        PH_LOW: if (tick_i) begin
          if (last_tick) begin
            phase_q <= PH_RISE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_RISE: if (scl_hi_i) begin
          phase_q <= PH_HIGH;
          cnt_q   <= '0;
        end
        PH_HIGH: if (tick_i) begin
          if (last_tick) begin
            phase_q <= PH_LOW;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scl_clk_div.sv
module scl_clk_div #(
  parameter int unsigned CDF_W       = 3,
  parameter int unsigned SCGD_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [CDF_W+SCGD_W-1:0] cfg_i,
  input  logic                    scl_i,
  output logic                    scl_oe_o,
  output logic                    tick_o,
  output logic                    shift_o,
  output logic                    sample_o
);
  localparam int unsigned CNT_W = SCGD_W + 3;

  logic             run;
  logic             load;
  logic             scl_hi;
  logic [CDF_W-1:0] cdf_q;
  logic [CNT_W-1:0] half_q;

  scl_cfg_latch #(.CDF_W(CDF_W), .SCGD_W(SCGD_W), .CNT_W(CNT_W)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .cfg_i (cfg_i),
    .cdf_o (cdf_q),
    .half_o(half_q)
  );

  scl_prescaler #(.CDF_W(CDF_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .cdf_i (cdf_q),
    .tick_o(tick_o)
  );

  scl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (scl_i),
    .q_o   (scl_hi)
  );

  scl_phase_ctrl #(.CNT_W(CNT_W)) u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .tick_i  (tick_o),
    .scl_hi_i(scl_hi),
    .half_i  (half_q),
    .run_o   (run),
    .load_o  (load),
    .scl_oe_o(scl_oe_o),
    .shift_o (shift_o),
    .sample_o(sample_o)
  );
endmodule

// File: rtl/scl_clk_div_chk.sv
module scl_clk_div_chk #(
  parameter int unsigned CDF_W = 3,
  parameter int unsigned CNT_W = 9
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             scl_oe_o,
  input logic             tick_o,
  input logic             shift_o,
  input logic             sample_o,
  input logic [CDF_W-1:0] cdf_q,
  input logic [CNT_W-1:0] half_q
);
  AST_RELEASE_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !scl_oe_o); // R7

  AST_QUIET_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!tick_o && !shift_o && !sample_o)); // R7

  AST_SHIFT_IN_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_o |-> scl_oe_o); // R8

  AST_SAMPLE_RELEASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> !scl_oe_o); // R8

  AST_STROBE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_o || sample_o) |-> tick_o); // R8

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && !$rose(scl_oe_o)) |-> ($stable(cdf_q) && $stable(half_q))); // R6
endmodule

bind scl_clk_div scl_clk_div_chk #(.CDF_W(CDF_W), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .scl_oe_o(scl_oe_o),
  .tick_o  (tick_o),
  .shift_o (shift_o),
  .sample_o(sample_o),
  .cdf_q   (cdf_q),
  .half_q  (half_q)
);

// File: tb/tb_scl_clk_div.sv
`timescale 1ns/1ps
module tb_scl_clk_div;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic       en1 = 1'b0, en2 = 1'b0, ext_low = 1'b0, sel = 1'b0;
  logic [8:0] cfg1 = '0;
  logic [7:0] cfg2 = '0;
  logic oe1, tick1, shf1, smp1, oe2, tick2, shf2, smp2;
  wire  scl1 = !oe1 && !ext_low;
  wire  scl2 = !oe2 && !ext_low;

  scl_clk_div dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en1), .cfg_i(cfg1), .scl_i(scl1),
    .scl_oe_o(oe1), .tick_o(tick1), .shift_o(shf1), .sample_o(smp1)
  );

  scl_clk_div #(.CDF_W(2)) dut_n2 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en2), .cfg_i(cfg2), .scl_i(scl2),
    .scl_oe_o(oe2), .tick_o(tick2), .shift_o(shf2), .sample_o(smp2)
  );

  wire oe_m   = sel ? oe2   : oe1;
  wire tick_m = sel ? tick2 : tick1;
  wire shf_m  = sel ? shf2  : shf1;
  wire smp_m  = sel ? smp2  : smp1;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic start(input logic s, input int cdf, input int scgd);
    en1 = 1'b0; en2 = 1'b0;
    @(negedge clk); @(negedge clk);
    sel = s;
    if (!s) cfg1 = {6'(scgd), 3'(cdf)};
    else    cfg2 = {6'(scgd), 2'(cdf)};
    if (!s) en1 = 1'b1; else en2 = 1'b1;
    @(negedge clk);
    chk("R9", "low phase after enable", int'(oe_m), 1);
  endtask

  // starts at first low cycle, ends at first low cycle of next period
  task automatic meas(input int s, output int low_c, output int rel_c, output int low_t,
                      output int rel_t, output int shf, output int smp);
    low_c = 0; rel_c = 0; low_t = 0; rel_t = 0; shf = 0; smp = 0;
    ext_low = 1'b1;
    while (oe_m) begin
      low_c++;
      if (tick_m) low_t++;
      if (shf_m) shf++;
      @(negedge clk);
    end
    while (!oe_m) begin
      if (rel_c == s) ext_low = 1'b0;
      rel_c++;
      if (tick_m) rel_t++;
      if (smp_m) smp++;
      @(negedge clk);
    end
    ext_low = 1'b0;
  endtask

  task automatic check_period(input string req, input int s, input int cdf, input int scgd);
    int lc, rc, lt, rt, sh, sm, h, p;
    h = 10 + 4 * scgd;
    p = cdf + 1;
    meas(s, lc, rc, lt, rt, sh, sm);
    chk({req, " R2"}, "low cycles", lc, h * p);
    chk({req, " R3"}, "released cycles", rc, h * p + 3 + s);
    chk({req, " R1"}, "low ticks", lt, h);
    chk({req, " R1"}, "high ticks", rt, h);
    chk({req, " R8"}, "shift pulses", sh, 1);
    chk({req, " R8"}, "sample pulses", sm, 1);
  endtask

  task automatic t_reset();
    chk("R7", "reset oe", int'(oe1), 0);
    chk("R7", "reset tick", int'(tick1), 0);
    chk("R7", "reset strobes", int'(shf1 | smp1), 0);
    chk("R7", "reset oe narrow", int'(oe2), 0);
  endtask

  task automatic t_basic();
    start(1'b0, 0, 0);
    check_period("R2_min", 0, 0, 0);
    check_period("R2_min_again", 0, 0, 0);
  endtask

  task automatic t_divided();
    start(1'b0, 3, 5);
    check_period("R1_div", 0, 3, 5);
  endtask

  task automatic t_tick_spacing();
    int c0, c1;
    start(1'b0, 5, 1);
    c0 = 0;
    while (!tick_m) begin c0++; @(negedge clk); end
    chk("R1", "cycles to first tick", c0, 5);
    c1 = 0;
    do begin @(negedge clk); c1++; end while (!tick_m);
    chk("R1", "tick spacing", c1, 6);
  endtask

  task automatic t_stretch();
    start(1'b0, 1, 2);
    check_period("R4", 7, 1, 2);
    check_period("R4_none", 0, 1, 2);
  endtask

  task automatic t_cfg_change();
    start(1'b0, 0, 1);
    cfg1 = {6'd3, 3'd2};
    check_period("R6_old", 0, 0, 1);
    check_period("R6_new", 0, 2, 3);
  endtask

  task automatic t_narrow();
    start(1'b1, 3, 4);
    check_period("R5_w2", 0, 3, 4);
    start(1'b1, 1, 0);
    check_period("R5_w2b", 0, 1, 0);
    sel = 1'b0;
    en2 = 1'b0;
  endtask

  task automatic t_max();
    start(1'b0, 7, 63);
    check_period("R5_max", 0, 7, 63);
  endtask

  task automatic t_disable();
    int act;
    start(1'b0, 0, 2);
    repeat (5) @(negedge clk);
    en1 = 1'b0;
    @(negedge clk);
    chk("R7", "oe after disable", int'(oe1), 0);
    act = 0;
    repeat (20) begin
      if (oe1 | tick1 | shf1 | smp1) act++;
      @(negedge clk);
    end
    chk("R7", "activity while disabled", act, 0);
    en1 = 1'b1;
    @(negedge clk);
    chk("R7", "oe after re-enable", int'(oe1), 1);
    check_period("R7_fresh", 0, 0, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_divided();
    t_tick_spacing();
    t_stretch();
    t_cfg_change();
    t_narrow();
    t_max();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule